// File: doc/BRIEF.md
# Width-Overlaid General Register File

This block holds sixteen 64-bit general registers and lets every access pick an operand width of 8, 16, 32 or 64 bits. Narrow views are overlaid on the low end of each register. For the first four registers there is also a second byte view that sits just above the low byte. One write port and two read ports share the same addressing scheme. A read returns its view right-aligned, with every bit above the view set to zero.

The width of a write decides what happens to the bits it does not cover. A 32-bit write clears the upper half of the register. An 8-bit or 16-bit write merges into the register and leaves every other bit as it was. A mode input selects between a 64-bit file and a reduced 32-bit file. In the reduced mode, the upper eight registers and the 64-bit width cannot be reached.

Any access that breaks these rules is refused and flagged. A refused write stores nothing. A refused read returns zero.

Top module: `gpr_alias_file`

## Requirements
- R1: After reset, every register reads as zero at every width.
- R2: The width code is 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. A legal read with the byte-select low returns bits 7:0, 15:0, 31:0 or 63:0 of the register. The result is right-aligned and every higher output bit is zero.
- R3: A legal 32-bit write stores the data's bits 31:0 in bits 31:0 and clears bits 63:32.
- R4: A legal 8-bit write with the byte-select low changes only bits 7:0. A legal 16-bit write changes only bits 15:0. All other bits keep their value.
- R5: An access with the byte-select high, width code 0 and index 0 to 3 addresses bits 15:8. On a write, bits 15:8 take data bits 7:0 and all other bits are kept. On a read, bits 15:8 are returned in output bits 7:0.
- R6: With `long_mode` at 0, an access is illegal if its index is 8 or above or its width code is 3. Any other access is legal in that mode.
- R7: A write flagged illegal leaves every register unchanged. A read flagged illegal returns all zeros.
- R8: A byte-select high with an index above 3, or with a width code other than 0, makes the access illegal in either mode.
- R9: Reads are combinational from stored state and have no bypass. A read of the register being written in the same cycle returns the value it held before the edge.
- R10: With `long_mode` at 1, a legal 64-bit write stores all 64 data bits, and registers 8 to 15 are reachable.
- R11: `wr_ready` is always 1. A write is taken at every rising edge where `wr_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| long_mode | input | 1 | 1: 64-bit file; 0: reduced 32-bit file |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be taken (always 1) |
| wr_idx | input | 4 | Write register index |
| wr_width | input | 2 | Write width code |
| wr_hi | input | 1 | Write byte-select for bits 15:8 |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | The current write request is illegal |
| rd_idx | input | 2x4 | Read index per port |
| rd_width | input | 2x2 | Read width code per port |
| rd_hi | input | 2x1 | Read byte-select per port |
| rd_data | output | 2x64 | Read data per port, zero-padded |
| rd_err | output | 2x1 | Read access illegal per port |

## Verification
The write port is never back-pressured, so the checks assume that each write with `wr_valid` high takes effect at the next edge. They also assume that `long_mode` and the write fields hold steady from one falling edge to the next. The stimulus changes inputs only at falling edges and leaves them unchanged through the following rising edge. The byte-select, index, width and mode are drawn over their whole code space, including the combinations that must be refused. This exercises the merge, zero-extend and refusal paths against one another.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    OPW_B = 2'd0,
    OPW_H = 2'd1,
    OPW_W = 2'd2,
    OPW_D = 2'd3
  } opw_e;
endpackage

// File: rtl/gpr_access_check.sv
module gpr_access_check
  import gpr_pkg::*;
#(
  parameter int unsigned LEGACY_REGS = 8,
  parameter int unsigned HI_REGS     = 4,
  parameter int unsigned IDXW        = 4
) (
  input  logic            long_mode,
  input  logic [IDXW-1:0] idx,
  input  opw_e            width,
  input  logic            hi,
  output logic            illegal
);
  logic hi_bad;
  logic legacy_bad;

  always_comb begin
    hi_bad     = hi && ((int'(idx) >= int'(HI_REGS)) || (width != OPW_B));
    legacy_bad = !long_mode && ((int'(idx) >= int'(LEGACY_REGS)) || (width == OPW_D));
    illegal    = hi_bad || legacy_bad;
  end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] data,
  input  opw_e            width,
  input  logic            hi,
  output logic [XLEN-1:0] new_val
);
  always_comb begin
    new_val = old_val;
    unique case (width)
      OPW_B: begin
        if (hi) new_val[15:8] = data[7:0];
        else    new_val[7:0]  = data[7:0];
      end
      OPW_H: new_val[15:0] = data[15:0];
      OPW_W: new_val = XLEN'(data[31:0]);
      OPW_D: new_val = data;
      default: new_val = old_val;
    endcase
  end
endmodule

// File: rtl/gpr_read_align.sv
module gpr_read_align
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] cur,
  input  opw_e            width,
  input  logic            hi,
  input  logic            kill,
  output logic [XLEN-1:0] data
);
  always_comb begin
    unique case (width)
      OPW_B:   data = hi ? XLEN'(cur[15:8]) : XLEN'(cur[7:0]);
      OPW_H:   data = XLEN'(cur[15:0]);
      OPW_W:   data = XLEN'(cur[31:0]);
      OPW_D:   data = cur;
      default: data = '0;
    endcase
    if (kill) data = '0;
  end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
  import gpr_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned LEGACY_REGS = 8,
  parameter int unsigned HI_REGS     = 4,
  parameter int unsigned XLEN        = 64,
  parameter int unsigned NUM_RD      = 2,
  localparam int unsigned IDXW       = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           long_mode,
  input  logic                           wr_valid,
  output logic                           wr_ready,
  input  logic [IDXW-1:0]                wr_idx,
  input  logic [1:0]                     wr_width,
  input  logic                           wr_hi,
  input  logic [XLEN-1:0]                wr_data,
  output logic                           wr_err,
  input  logic [NUM_RD-1:0][IDXW-1:0]    rd_idx,
  input  logic [NUM_RD-1:0][1:0]         rd_width,
  input  logic [NUM_RD-1:0]              rd_hi,
  output logic [NUM_RD-1:0][XLEN-1:0]    rd_data,
  output logic [NUM_RD-1:0]              rd_err
);
  logic [NUM_REGS-1:0][XLEN-1:0] reg_q;
  logic                          wr_illegal;
  logic                          wr_fire;
  logic [XLEN-1:0]               wr_next;

  assign wr_ready = 1'b1;

  gpr_access_check #(
    .LEGACY_REGS(LEGACY_REGS), .HI_REGS(HI_REGS), .IDXW(IDXW)
  ) u_wchk (
    .long_mode(long_mode),
    .idx      (wr_idx),
    .width    (opw_e'(wr_width)),
    .hi       (wr_hi),
    .illegal  (wr_illegal)
  );

  assign wr_err  = wr_valid && wr_illegal;
  assign wr_fire = wr_valid && !wr_illegal;

  gpr_write_merge #(.XLEN(XLEN)) u_merge (
    .old_val(reg_q[wr_idx]),
    .data   (wr_data),
    .width  (opw_e'(wr_width)),
    .hi     (wr_hi),
    .new_val(wr_next)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                  reg_q[gi] <= '0;
      else if (wr_fire && (int'(wr_idx) == gi))    reg_q[gi] <= wr_next;
    end
  end

  for (genvar gp = 0; gp < NUM_RD; gp++) begin : g_rd
    logic rd_illegal;

    gpr_access_check #(
      .LEGACY_REGS(LEGACY_REGS), .HI_REGS(HI_REGS), .IDXW(IDXW)
    ) u_rchk (
      .long_mode(long_mode),
      .idx      (rd_idx[gp]),
      .width    (opw_e'(rd_width[gp])),
      .hi       (rd_hi[gp]),
      .illegal  (rd_illegal)
    );

    gpr_read_align #(.XLEN(XLEN)) u_align (
      .cur  (reg_q[rd_idx[gp]]),
      .width(opw_e'(rd_width[gp])),
      .hi   (rd_hi[gp]),
      .kill (rd_illegal),
      .data (rd_data[gp])
    );

    assign rd_err[gp] = rd_illegal;
  end
endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NUM_RD   = 2,
  localparam int unsigned IDXW    = $clog2(NUM_REGS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        long_mode,
  input logic                        wr_valid,
  input logic [IDXW-1:0]             wr_idx,
  input logic [1:0]                  wr_width,
  input logic                        wr_hi,
  input logic [XLEN-1:0]             wr_data,
  input logic                        wr_err,
  input logic [NUM_RD-1:0][XLEN-1:0] rd_data,
  input logic [NUM_RD-1:0]           rd_err,
  input logic [NUM_REGS-1:0][XLEN-1:0] regs
);
  logic [XLEN-1:0] tgt;
  logic            ok_wr;
  assign tgt   = regs[wr_idx];
  assign ok_wr = wr_valid && !wr_err;

  assert_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && wr_width == 2'd2) |=>
      (regs[$past(wr_idx)] == XLEN'($past(wr_data[31:0]))));

  assert_keep_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && wr_width == 2'd1) |=>
      (regs[$past(wr_idx)][XLEN-1:16] == $past(tgt[XLEN-1:16])));

  assert_hi_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && wr_hi) |=>
      (regs[$past(wr_idx)][15:8] == $past(wr_data[7:0]) &&
       regs[$past(wr_idx)][7:0]  == $past(tgt[7:0])));

  assert_legacy_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !long_mode && (int'(wr_idx) >= 8 || wr_width == 2'd3)) |-> wr_err);

  assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_wr |=> $stable(regs));

  assert_hi_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_hi && (int'(wr_idx) > 3 || wr_width != 2'd0)) |-> wr_err);

  for (genvar gp = 0; gp < NUM_RD; gp++) begin : g_rdchk
    assert_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err[gp] |-> (rd_data[gp] == '0));
  end
endmodule

bind gpr_alias_file gpr_alias_file_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .long_mode(long_mode),
  .wr_valid (wr_valid),
  .wr_idx   (wr_idx),
  .wr_width (wr_width),
  .wr_hi    (wr_hi),
  .wr_data  (wr_data),
  .wr_err   (wr_err),
  .rd_data  (rd_data),
  .rd_err   (rd_err),
  .regs     (reg_q)
);

// File: tb/sim_gpr_alias_file.sv
module sim_gpr_alias_file;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              long_mode = 1'b1;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [3:0]        wr_idx = '0;
  logic [1:0]        wr_width = '0;
  logic              wr_hi = 1'b0;
  logic [63:0]       wr_data = '0;
  logic              wr_err;
  logic [1:0][3:0]   rd_idx = '0;
  logic [1:0][1:0]   rd_width = '0;
  logic [1:0]        rd_hi = '0;
  logic [1:0][63:0]  rd_data;
  logic [1:0]        rd_err;

  int   nchk = 0;
  int   nfail = 0;
  bit   done = 0;
  logic [63:0] mdl [16];

  always #2.5 clk = ~clk;

  gpr_alias_file u0 (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_width(wr_width), .wr_hi(wr_hi), .wr_data(wr_data), .wr_err(wr_err),
    .rd_idx(rd_idx), .rd_width(rd_width), .rd_hi(rd_hi),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  function automatic bit legal(bit lm, int idx, int w, bit hi);
    if (hi && (idx > 3 || w != 0)) return 0;
    if (!lm && (idx >= 8 || w == 3)) return 0;
    return 1;
  endfunction

  function automatic logic [63:0] view(bit lm, int idx, int w, bit hi);
    logic [63:0] r;
    if (!legal(lm, idx, w, hi)) return 64'd0;
    r = mdl[idx];
    if (hi) return {56'd0, r[15:8]};
    case (w)
      0: return {56'd0, r[7:0]};
      1: return {48'd0, r[15:0]};
      2: return {32'd0, r[31:0]};
      default: return r;
    endcase
  endfunction

  function automatic logic [63:0] merged(logic [63:0] r, int w, bit hi, logic [63:0] d);
    logic [63:0] n;
    n = r;
    if (w == 0 && hi) n[15:8] = d[7:0];
    else if (w == 0)  n[7:0] = d[7:0];
    else if (w == 1)  n[15:0] = d[15:0];
    else if (w == 2)  n = {32'd0, d[31:0]};
    else              n = d;
    return n;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit lm, bit wv, int wi, int ww, bit wh, logic [63:0] wd,
                     int ai, int aw, bit ah, int bi, int bw, bit bh, string tag);
    @(negedge clk);
    long_mode   = lm;
    wr_valid    = wv;
    wr_idx      = 4'(wi);
    wr_width    = 2'(ww);
    wr_hi       = wh;
    wr_data     = wd;
    rd_idx[0]   = 4'(ai);
    rd_width[0] = 2'(aw);
    rd_hi[0]    = ah;
    rd_idx[1]   = 4'(bi);
    rd_width[1] = 2'(bw);
    rd_hi[1]    = bh;
    #1;
    check({tag, " rd0"}, rd_data[0], view(lm, ai, aw, ah));
    check({tag, " rd1"}, rd_data[1], view(lm, bi, bw, bh));
    check({tag, " rderr0"}, {63'd0, rd_err[0]}, {63'd0, !legal(lm, ai, aw, ah)});
    check({tag, " rderr1"}, {63'd0, rd_err[1]}, {63'd0, !legal(lm, bi, bw, bh)});
    check({tag, " wrerr"}, {63'd0, wr_err}, {63'd0, wv && !legal(lm, wi, ww, wh)});
    check("R11 ready", {63'd0, wr_ready}, 64'd1);
    if (wv && legal(lm, wi, ww, wh)) mdl[wi] = merged(mdl[wi], ww, wh, wd);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 0; i < 16; i += 2) cyc(1, 0, 0, 0, 0, 0, i, 3, 0, i + 1, 3, 0, "R1");
    cyc(1, 0, 0, 0, 0, 0, 2, 0, 1, 3, 1, 0, "R1 narrow");

    // R10: full-width writes, upper registers reachable
    cyc(1, 1, 5, 3, 0, 64'h0123_4567_89AB_CDEF, 5, 3, 0, 12, 3, 0, "R10");
    cyc(1, 1, 12, 3, 0, 64'hFEDC_BA98_7654_3210, 5, 3, 0, 12, 3, 0, "R10");
    cyc(1, 0, 0, 0, 0, 0, 12, 3, 0, 12, 2, 0, "R10 readback");

    // R9: same-cycle read returns the old value
    cyc(1, 1, 5, 0, 0, 64'hFFFF_FFFF_FFFF_FFAA, 5, 3, 0, 5, 0, 0, "R9");
    // R4: byte and halfword merges
    cyc(1, 0, 0, 0, 0, 0, 5, 3, 0, 5, 0, 0, "R4 byte");
    cyc(1, 1, 5, 1, 0, 64'h1111_2222_3333_BEEF, 5, 3, 0, 5, 1, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, 5, 3, 0, 5, 1, 0, "R4 half");
    // R3: 32-bit write zero-extends
    cyc(1, 1, 5, 2, 0, 64'hAAAA_BBBB_1122_3344, 5, 3, 0, 5, 2, 0, "R3");
    cyc(1, 0, 0, 0, 0, 0, 5, 3, 0, 5, 2, 0, "R3 readback");

    // R5: high byte of a low register
    cyc(1, 1, 2, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 2, 3, 0, 2, 0, 1, "R5");
    cyc(1, 1, 2, 0, 1, 64'h0000_0000_0000_005A, 2, 3, 0, 2, 0, 1, "R5");
    cyc(1, 0, 0, 0, 0, 0, 2, 3, 0, 2, 0, 1, "R5 readback");
    cyc(1, 1, 3, 0, 1, 64'h0000_0000_0000_00C3, 3, 0, 1, 3, 1, 0, "R5 r3");
    cyc(1, 0, 0, 0, 0, 0, 3, 0, 1, 3, 1, 0, "R5 r3 readback");

    // R8: high byte illegal above index 3 or with a wider width
    cyc(1, 1, 6, 0, 1, 64'h77, 6, 0, 1, 1, 1, 1, "R8");
    cyc(1, 1, 1, 1, 1, 64'h77, 6, 3, 0, 1, 3, 0, "R8 width");
    cyc(1, 0, 0, 0, 0, 0, 6, 3, 0, 1, 3, 0, "R8 unchanged");

    // R6: reduced mode rejects upper registers and 64-bit width
    cyc(0, 1, 9, 2, 0, 64'h5555_5555, 12, 3, 0, 5, 2, 0, "R6");
    cyc(0, 1, 3, 3, 0, 64'h9999_9999_9999_9999, 12, 2, 0, 3, 3, 0, "R6");
    cyc(0, 1, 1, 2, 0, 64'hDEAD_BEEF_CAFE_F00D, 1, 2, 0, 2, 0, 1, "R6 legal");
    // R7: rejected writes left everything unchanged
    cyc(1, 0, 0, 0, 0, 0, 9, 3, 0, 3, 3, 0, "R7");
    cyc(1, 0, 0, 0, 0, 0, 1, 3, 0, 12, 3, 0, "R7");

    // R2: mixed traffic over the whole code space
    for (int n = 0; n < 3000; n++) begin
      bit lm;
      lm = ($urandom_range(0, 3) != 0);
      cyc(lm, 1'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom_range(0, 3),
          ($urandom_range(0, 5) == 0), {$urandom, $urandom},
          $urandom_range(0, 15), $urandom_range(0, 3), ($urandom_range(0, 5) == 0),
          $urandom_range(0, 3), $urandom_range(0, 3), ($urandom_range(0, 3) == 0),
          "R2 random");
    end

    for (int i = 0; i < 16; i += 2) cyc(1, 0, 0, 0, 0, 0, i, 3, 0, i + 1, 3, 0, "R2 final");

    done = 1;
    summary();
    $finish;
  end
endmodule